// File: doc/BRIEF.md
# Debug Data-Transfer Mailbox with Latched Full Flags

This block is a two-way mailbox between an external debug port and an internal processor port. The receive path carries words from the debugger to the core. The transmit path carries words from the core to the debugger. Each path has one data register and two full flags. The live flag tracks whether the register holds a word. The latched flag records the state the debugger last observed.

Only non-blocking operation is built. Debugger accesses are admitted according to the latched flags. A latched flag is refreshed when the debugger reads the status word, when it completes a receive write, or when it completes a transmit read. Because of this, the debugger cannot overwrite a word it has not seen drained, and it cannot consume a word it has not seen arrive. Core accesses are admitted according to the live flags.

The status word is always visible on its read port. Asserting the status-read strobe is the event that refreshes the latched flags.

Top module: `dbg_xfer_mailbox`

## Requirements
- R1: After reset both data registers are zero and all four flags are clear. The status word is laid out as follows: bits [1:0] hold the mode field, which always reads 0b00 (non-blocking); bit 2 is the live receive-full flag; bit 3 is the live transmit-full flag; bit 4 is the latched receive-full flag; bit 5 is the latched transmit-full flag.
- R2: A core read of the receive register while the live receive flag is set returns the word and clears the live flag. The latched receive flag stays set until its next refresh.
- R3: A debugger receive write while the latched receive flag is set is ignored. The data register and both receive flags keep their values.
- R4: A debugger status read copies the live flags into the latched flags. The values copied are the live flags after any core access in the same cycle.
- R5: A debugger receive write while the latched receive flag is clear stores the word and sets both receive flags. A second write with no status read in between is therefore rejected.
- R6: A debugger transmit read while the latched transmit flag is set returns the word, raises the read-valid output and clears both transmit flags. A further read after the core refills the register, with no status read in between, is rejected.
- R7: A debugger transmit read while the latched transmit flag is clear keeps read-valid low and changes no flag.
- R8: A core transmit write while the live transmit flag is clear stores the word, raises core write-accept and sets the live flag. The latched transmit flag does not change.
- R9: A core transmit write while the live transmit flag is set is dropped: write-accept stays low and the stored word is kept.
- R10: A core receive read while the live receive flag is clear keeps read-valid low, returns the stale word and changes no flag.
- R11: A status read in the same cycle as a core receive read latches a clear receive flag. A status read in the same cycle as an accepted core transmit write latches a set transmit flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_rx_wr | input | 1 | Debugger write strobe for the receive register |
| dbg_rx_wdata | input | DATA_W | Debugger write data |
| dbg_tx_rd | input | 1 | Debugger read strobe for the transmit register |
| dbg_tx_rdata | output | DATA_W | Transmit register contents |
| dbg_tx_rd_ok | output | 1 | The current debugger transmit read is accepted |
| dbg_stat_rd | input | 1 | Debugger status read strobe (refreshes the latched flags) |
| dbg_status | output | 6 | Status word: mode, live flags, latched flags |
| core_rx_rd | input | 1 | Core read strobe for the receive register |
| core_rx_rdata | output | DATA_W | Receive register contents |
| core_rx_rd_ok | output | 1 | The current core receive read found a word |
| core_tx_wr | input | 1 | Core write strobe for the transmit register |
| core_tx_wdata | input | DATA_W | Core write data |
| core_tx_wr_ok | output | 1 | The current core transmit write is accepted |

## Verification
If a latched flag holds a wrong value, the next status word shows it, and the next debugger access is admitted or refused wrongly in the same cycle it is issued. A lost or overwritten word shows up at the other side's data port on its next successful access. The bench runs the drain-then-rewrite and refill-then-reread sequences without intervening status reads, plus status reads that coincide with core accesses. This covers both the race hazard and the ordering of updates within a cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int STAT_W      = 6;
    localparam int ST_MODE_LSB = 0;
    localparam int ST_RX_LIVE  = 2;
    localparam int ST_TX_LIVE  = 3;
    localparam int ST_RX_LAT   = 4;
    localparam int ST_TX_LAT   = 5;

    typedef enum logic [1:0] {
        MODE_NONBLOCK = 2'b00,
        MODE_RSVD1    = 2'b01,
        MODE_RSVD2    = 2'b10,
        MODE_RSVD3    = 2'b11
    } xfer_mode_e;

    typedef struct packed {
        logic live;
        logic seen;
    } flag_pair_t;
endpackage

// File: rtl/mbx_rx_path.sv
module mbx_rx_path
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_wr,
    input  logic [DATA_W-1:0] dbg_wdata,
    input  logic              dbg_stat_rd,
    input  logic              core_rd,
    output logic [DATA_W-1:0] core_rdata,
    output logic              core_rd_ok,
    output logic              full,
    output logic              full_l
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        flag_pair_t        flg;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      live_after_core;
    logic      wr_take;

    always_comb begin
        st_d            = st_q;
        // Core access on the live flag comes first.
        live_after_core = st_q.flg.live & ~core_rd;
        st_d.flg.live   = live_after_core;
        // Debugger write is admitted by the latched flag only.
        wr_take         = dbg_wr & ~st_q.flg.seen;
        if (wr_take) begin
            st_d.data     = dbg_wdata;
            st_d.flg.live = 1'b1;
            st_d.flg.seen = 1'b1;
        end else if (dbg_stat_rd) begin
            st_d.flg.seen = live_after_core;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign core_rdata = st_q.data;
    assign core_rd_ok = core_rd & st_q.flg.live;
    assign full       = st_q.flg.live;
    assign full_l     = st_q.flg.seen;

    // R3
    rx_reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_wr && full_l) |=> $stable(core_rdata));
    // R5
    rx_accept_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_wr && !full_l) |=> (full && full_l));
    // R2
    rx_core_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rd && full && !dbg_stat_rd) |=> (!full && full_l));
    // R10
    rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rd && !full) |-> !core_rd_ok);
endmodule

// File: rtl/mbx_tx_path.sv
module mbx_tx_path
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_rd,
    input  logic              dbg_stat_rd,
    output logic [DATA_W-1:0] dbg_rdata,
    output logic              dbg_rd_ok,
    input  logic              core_wr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              core_wr_ok,
    output logic              full,
    output logic              full_l
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        flag_pair_t        flg;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic      live_after_core;
    logic      wr_take;
    logic      rd_take;

    always_comb begin
        st_d            = st_q;
        // Core write is admitted by the live flag and applied first.
        wr_take         = core_wr & ~st_q.flg.live;
        live_after_core = st_q.flg.live | wr_take;
        if (wr_take) st_d.data = core_wdata;
        st_d.flg.live   = live_after_core;
        // Debugger read is admitted by the latched flag only.
        rd_take         = dbg_rd & st_q.flg.seen;
        if (rd_take) begin
            st_d.flg.live = 1'b0;
            st_d.flg.seen = 1'b0;
        end else if (dbg_stat_rd) begin
            st_d.flg.seen = live_after_core;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dbg_rdata  = st_q.data;
    assign dbg_rd_ok  = rd_take;
    assign core_wr_ok = wr_take;
    assign full       = st_q.flg.live;
    assign full_l     = st_q.flg.seen;

    // R6
    tx_accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_rd && full_l) |=> (!full && !full_l));
    // R7
    tx_reject_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_rd && !full_l && !dbg_stat_rd) |=> !full_l);
    // R9
    tx_drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr && full) |=> $stable(dbg_rdata));
    // R8
    tx_core_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr && !full && !dbg_rd && !dbg_stat_rd) |=> (full && $stable(full_l)));
endmodule

// File: rtl/dbg_xfer_mailbox.sv
module dbg_xfer_mailbox
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_rx_wr,
    input  logic [DATA_W-1:0] dbg_rx_wdata,
    input  logic              dbg_tx_rd,
    output logic [DATA_W-1:0] dbg_tx_rdata,
    output logic              dbg_tx_rd_ok,
    input  logic              dbg_stat_rd,
    output logic [5:0]        dbg_status,
    input  logic              core_rx_rd,
    output logic [DATA_W-1:0] core_rx_rdata,
    output logic              core_rx_rd_ok,
    input  logic              core_tx_wr,
    input  logic [DATA_W-1:0] core_tx_wdata,
    output logic              core_tx_wr_ok
);
    logic rx_full, rx_full_l, tx_full, tx_full_l;
    logic [STAT_W-1:0] stat_w;

    mbx_rx_path #(.DATA_W(DATA_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .dbg_wr      (dbg_rx_wr),
        .dbg_wdata   (dbg_rx_wdata),
        .dbg_stat_rd (dbg_stat_rd),
        .core_rd     (core_rx_rd),
        .core_rdata  (core_rx_rdata),
        .core_rd_ok  (core_rx_rd_ok),
        .full        (rx_full),
        .full_l      (rx_full_l)
    );

    mbx_tx_path #(.DATA_W(DATA_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .dbg_rd      (dbg_tx_rd),
        .dbg_stat_rd (dbg_stat_rd),
        .dbg_rdata   (dbg_tx_rdata),
        .dbg_rd_ok   (dbg_tx_rd_ok),
        .core_wr     (core_tx_wr),
        .core_wdata  (core_tx_wdata),
        .core_wr_ok  (core_tx_wr_ok),
        .full        (tx_full),
        .full_l      (tx_full_l)
    );

    always_comb begin
        stat_w                              = '0;
        stat_w[ST_MODE_LSB+1:ST_MODE_LSB]   = MODE_NONBLOCK;
        stat_w[ST_RX_LIVE]                  = rx_full;
        stat_w[ST_TX_LIVE]                  = tx_full;
        stat_w[ST_RX_LAT]                   = rx_full_l;
        stat_w[ST_TX_LAT]                   = tx_full_l;
    end

    assign dbg_status = stat_w;

    // R4
    stat_rx_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_stat_rd && !dbg_rx_wr) |=> (rx_full_l == $past(rx_full && !core_rx_rd)));
    // R11
    stat_tx_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_stat_rd && !dbg_tx_rd) |=> (tx_full_l == $past(tx_full || core_tx_wr)));
    // R1
    stat_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_status[1:0] == 2'b00);
endmodule

// File: tb/tb_dbg_xfer_mailbox.sv
module tb_dbg_xfer_mailbox;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dbg_rx_wr = 0, dbg_tx_rd = 0, dbg_stat_rd = 0, core_rx_rd = 0, core_tx_wr = 0;
    logic [W-1:0] dbg_rx_wdata = '0, core_tx_wdata = '0;
    logic [W-1:0] dbg_tx_rdata, core_rx_rdata;
    logic dbg_tx_rd_ok, core_rx_rd_ok, core_tx_wr_ok;
    logic [5:0] dbg_status;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dbg_xfer_mailbox #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .dbg_rx_wr(dbg_rx_wr), .dbg_rx_wdata(dbg_rx_wdata),
        .dbg_tx_rd(dbg_tx_rd), .dbg_tx_rdata(dbg_tx_rdata), .dbg_tx_rd_ok(dbg_tx_rd_ok),
        .dbg_stat_rd(dbg_stat_rd), .dbg_status(dbg_status),
        .core_rx_rd(core_rx_rd), .core_rx_rdata(core_rx_rdata), .core_rx_rd_ok(core_rx_rd_ok),
        .core_tx_wr(core_tx_wr), .core_tx_wdata(core_tx_wdata), .core_tx_wr_ok(core_tx_wr_ok)
    );

    // status bits: [5] tx latched, [4] rx latched, [3] tx live, [2] rx live, [1:0] mode
    function automatic logic [5:0] st(input logic txl, rxl, txv, rxv);
        return {txl, rxl, txv, rxv, 2'b00};
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_cycle();
        @(posedge clk);
        #1;
        dbg_rx_wr = 0; dbg_tx_rd = 0; dbg_stat_rd = 0; core_rx_rd = 0; core_tx_wr = 0;
        #1;
    endtask

    task automatic t_reset();
        check("R1 status", {26'd0, dbg_status}, {26'd0, st(0,0,0,0)});
        check("R1 rx data", core_rx_rdata, '0);
        check("R1 tx data", dbg_tx_rdata, '0);
    endtask

    task automatic t_rx_flow();
        dbg_stat_rd = 1; finish_cycle();
        dbg_rx_wr = 1; dbg_rx_wdata = 32'hA1A1_0001; finish_cycle();
        check("R5 both set", {26'd0, dbg_status}, {26'd0, st(0,1,0,1)});
        dbg_rx_wr = 1; dbg_rx_wdata = 32'hB2B2_0002; finish_cycle();
        check("R3 second write rejected", core_rx_rdata, 32'hA1A1_0001);
        check("R3 flags kept", {26'd0, dbg_status}, {26'd0, st(0,1,0,1)});
        core_rx_rd = 1; #1;
        check("R2 core read ok", {31'd0, core_rx_rd_ok}, 1);
        finish_cycle();
        check("R2 live clear latched set", {26'd0, dbg_status}, {26'd0, st(0,1,0,0)});
        dbg_rx_wr = 1; dbg_rx_wdata = 32'hC3C3_0003; finish_cycle();
        check("R3 write after drain w/o status", core_rx_rdata, 32'hA1A1_0001);
        check("R3 flags after ignored", {26'd0, dbg_status}, {26'd0, st(0,1,0,0)});
        core_rx_rd = 1; #1;
        check("R10 empty read not ok", {31'd0, core_rx_rd_ok}, 0);
        check("R10 stale data", core_rx_rdata, 32'hA1A1_0001);
        finish_cycle();
        check("R10 flags unchanged", {26'd0, dbg_status}, {26'd0, st(0,1,0,0)});
        dbg_stat_rd = 1; finish_cycle();
        check("R4 refresh rx", {26'd0, dbg_status}, {26'd0, st(0,0,0,0)});
        dbg_rx_wr = 1; dbg_rx_wdata = 32'hD4D4_0004; finish_cycle();
        core_rx_rd = 1; #1;
        check("R5 new word", core_rx_rdata, 32'hD4D4_0004);
        finish_cycle();
        dbg_stat_rd = 1; finish_cycle();
    endtask

    task automatic t_tx_flow();
        core_tx_wr = 1; core_tx_wdata = 32'h1111_AAAA; #1;
        check("R8 write accept", {31'd0, core_tx_wr_ok}, 1);
        finish_cycle();
        check("R8 live set latched clear", {26'd0, dbg_status}, {26'd0, st(0,0,1,0)});
        dbg_tx_rd = 1; #1;
        check("R7 read refused", {31'd0, dbg_tx_rd_ok}, 0);
        finish_cycle();
        check("R7 flags unchanged", {26'd0, dbg_status}, {26'd0, st(0,0,1,0)});
        dbg_stat_rd = 1; finish_cycle();
        check("R4 refresh tx", {26'd0, dbg_status}, {26'd0, st(1,0,1,0)});
        core_tx_wr = 1; core_tx_wdata = 32'h2222_BBBB; #1;
        check("R9 write refused", {31'd0, core_tx_wr_ok}, 0);
        finish_cycle();
        dbg_tx_rd = 1; #1;
        check("R6 read ok", {31'd0, dbg_tx_rd_ok}, 1);
        check("R9 first word kept", dbg_tx_rdata, 32'h1111_AAAA);
        finish_cycle();
        check("R6 both clear", {26'd0, dbg_status}, {26'd0, st(0,0,0,0)});
        core_tx_wr = 1; core_tx_wdata = 32'h3333_CCCC; finish_cycle();
        dbg_tx_rd = 1; #1;
        check("R6 reread after refill refused", {31'd0, dbg_tx_rd_ok}, 0);
        finish_cycle();
        check("R6 flags after refused", {26'd0, dbg_status}, {26'd0, st(0,0,1,0)});
        dbg_stat_rd = 1; finish_cycle();
        dbg_tx_rd = 1; #1;
        check("R6 read after status", {31'd0, dbg_tx_rd_ok}, 1);
        check("R6 refill data", dbg_tx_rdata, 32'h3333_CCCC);
        finish_cycle();
    endtask

    task automatic t_same_cycle();
        dbg_rx_wr = 1; dbg_rx_wdata = 32'h5555_0005; finish_cycle();
        dbg_stat_rd = 1; core_rx_rd = 1; core_tx_wr = 1; core_tx_wdata = 32'h6666_0006;
        finish_cycle();
        check("R11 post-core latch", {26'd0, dbg_status}, {26'd0, st(1,0,1,0)});
        dbg_rx_wr = 1; dbg_rx_wdata = 32'h7777_0007; finish_cycle();
        check("R11 rx write admitted", core_rx_rdata, 32'h7777_0007);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1; rst_n = 1; #1;
        t_reset();
        t_rx_flow();
        t_tx_flow();
        t_same_cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule